// File: doc/BRIEF.md
# Frame-Synchronous PCM Serial Port

This block is the digital sample interface of a voice codec. It runs on a fast system clock and oversamples three external lines: a bit clock, a frame sync and a serial data input. A rising frame sync marks the start of a frame. The port then shifts in one 14-bit two's-complement receive sample and delivers it as a parallel word. In the same frame it shifts out one 14-bit transmit sample on an open-drain serial output.

Both directions are most significant bit first. The MSB carries the sign. The serial output only ever pulls low, and an external pull-up supplies the high level. Outside the 14 active bit periods the output is released.

An activity monitor watches the bit clock and the frame sync. When either line stops toggling for longer than its timeout, the port enters power saving and abandons any frame in progress. It returns to operation on the first frame sync that arrives while the bit clock is running, and that frame is handled normally. A low level on the power-enable input forces the port into an idle, power-down state.

The transmit side is a valid/ready sink. `tx_ready` is a one-cycle pulse at each accepted frame start, and the word on `tx_data` is taken in that cycle if `tx_valid` is high. Without a valid word the frame carries zero (silence). The source must therefore hold `tx_valid` and `tx_data` until it sees the pulse.

The receive side is a valid/ready source with no back-pressure on the line, because a frame cannot be stalled. `rx_valid` stays high and `rx_data` stays stable until `rx_ready` is seen. A word that arrives before the previous one is taken replaces it.

Top module: `pcm_frame_port`

## Requirements
- R1: Serial input bits are sampled on falling edges of the bit clock. The first falling edge after a frame sync rising edge carries the MSB (bit 13). The next 13 falling edges carry bits 12 down to 0.
- R2: A received word appears on `rx_data` with `rx_valid` high a few system cycles after the 14th falling edge. It stays valid and unchanged until `rx_ready` is high, and `rx_valid` drops in the cycle after that. A newer word overwrites an unread one.
- R3: The transmit word is captured at frame start, when `tx_ready` pulses once and `tx_valid` is high. It is sent MSB first, one bit per bit clock rising edge. If `tx_valid` is low, fourteen zero bits are sent.
- R4: The MSB is launched at the frame sync edge itself if the bit clock is already high at that moment. If the bit clock is low, the MSB is launched at the next bit clock rising edge.
- R5: The output is released at the bit clock rising edge that ends the 14th bit. Any further bit periods in the frame stay undriven.
- R6: `sdo_pull_low` is high only during an active bit whose value is 0. A 1 bit is left to the pull-up.
- R7: If the bit clock shows no edge for `BCLK_TMO` system cycles, `pwr_save` goes high, the output is released and a partial frame is abandoned.
- R8: If no frame sync rising edge arrives for `SYNC_TMO` system cycles, `pwr_save` goes high even while the bit clock runs.
- R9: After reset the port sits in power saving with the output released and no valid word. The port leaves power saving on the first frame sync rising edge seen while the bit clock is active, and that frame is handled normally.
- R10: While `pwr_on` is low, `pwr_save` is high, `rx_valid` is low, the output is released and no frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | 1 = operate, 0 = power down |
| bclk | input | 1 | External bit clock (asynchronous) |
| fsync | input | 1 | External frame sync (asynchronous) |
| sdin | input | 1 | Serial receive data |
| sdo_pull_low | output | 1 | Open-drain output: 1 pulls the line low, 0 releases it |
| tx_data | input | 14 | Transmit sample, two's complement |
| tx_valid | input | 1 | Transmit sample available |
| tx_ready | output | 1 | One-cycle pulse at an accepted frame start |
| rx_data | output | 14 | Received sample, two's complement |
| rx_valid | output | 1 | Received sample available |
| rx_ready | input | 1 | Consumer takes the received sample |
| pwr_save | output | 1 | Port is in power saving or power down |

## Verification
The assertions check four things on every cycle:
- the output stays released while in power saving;
- power down idles the port;
- an unread receive word holds steady;
- a new word appears only after a bit clock falling edge, and a transmit bit changes only at a bit clock rise or a frame start.

Only the bench's scenarios can show the rest:
- the bit order and two's-complement content of whole frames;
- the launch choice between the sync edge and the clock edge;
- release after the 14th bit;
- recovery from power saving after a stall of either line.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef struct packed {
    logic bclk_rise;
    logic bclk_fall;
    logic fs_rise;
  } line_evt_t;
endpackage

// File: rtl/pcm_line_sync.sv
module pcm_line_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] level
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], pin};
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/pcm_activity_mon.sv
module pcm_activity_mon #(
  parameter int unsigned BCLK_TMO = 64,
  parameter int unsigned SYNC_TMO = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  input  logic bclk_edge,
  input  logic fs_rise,
  output logic frame_start,
  output logic halt,
  output logic saving
);
  localparam int unsigned TMAX = (BCLK_TMO > SYNC_TMO) ? BCLK_TMO : SYNC_TMO;
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [1:0][CW-1:0] RELOAD = {CW'(SYNC_TMO), CW'(BCLK_TMO)};

  logic [1:0] kick;
  logic [1:0] dead;

  assign kick = {fs_rise, bclk_edge};

  for (genvar k = 0; k < 2; k++) begin : g_wd
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!pwr_on)       cnt <= '0;
      else if (kick[k])       cnt <= RELOAD[k];
      else if (cnt != '0)     cnt <= cnt - 1'b1;
    end
    assign dead[k] = (cnt == '0) && !kick[k];
  end

  assign frame_start = pwr_on && fs_rise && !dead[0];
  assign halt        = !pwr_on || (|dead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           saving <= 1'b1;
    else if (!pwr_on)     saving <= 1'b1;
    else if (frame_start) saving <= 1'b0;
    else if (|dead)       saving <= 1'b1;
  end
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt,
  input  logic         start,
  input  logic         bclk_high,
  input  logic         bclk_rise,
  input  logic [W-1:0] word,
  output logic         pull_low
);
  localparam int CW = $clog2(W);

  logic          active, armed, bit_q;
  logic [W-1:0]  sh;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; armed <= 1'b0; bit_q <= 1'b1; sh <= '0; left <= '0;
    end else if (halt) begin
      active <= 1'b0; armed <= 1'b0;
    end else if (start) begin
      if (bclk_high) begin
        active <= 1'b1; armed <= 1'b0;
        bit_q  <= word[W-1]; sh <= word << 1; left <= CW'(W-1);
      end else begin
        active <= 1'b0; armed <= 1'b1; sh <= word;
      end
    end else if (bclk_rise) begin
      if (armed) begin
        armed <= 1'b0; active <= 1'b1;
        bit_q <= sh[W-1]; sh <= sh << 1; left <= CW'(W-1);
      end else if (active) begin
        if (left == '0) active <= 1'b0;
        else begin
          bit_q <= sh[W-1]; sh <= sh << 1; left <= left - 1'b1;
        end
      end
    end
  end

  assign pull_low = active && !bit_q;

  // R3: a driven bit only moves at a bit clock rise or a frame start
  assert_bit_moves_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bclk_rise && !start && !halt) |=> (active && $stable(bit_q)));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt,
  input  logic         flush,
  input  logic         start,
  input  logic         bclk_fall,
  input  logic         sdin,
  input  logic         rdy,
  output logic [W-1:0] data,
  output logic         valid
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] left;
  logic          done;

  assign done = bclk_fall && (left == CW'(1)) && !halt && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; left <= '0;
    end else if (halt) begin
      left <= '0;
    end else if (start) begin
      left <= CW'(W);
    end else if (bclk_fall && left != '0) begin
      sh   <= {sh[W-2:0], sdin};
      left <= left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; data <= '0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (done) begin
      valid <= 1'b1; data <= {sh[W-2:0], sdin};
    end else if (rdy) begin
      valid <= 1'b0;
    end
  end

  // R2: an unread word holds steady
  assert_hold_until_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rdy && !flush && !done) |=> (valid && $stable(data)));
  // R1: a new word only follows a bit clock falling edge
  assert_word_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(bclk_fall));
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
  import pcm_port_pkg::*;
#(
  parameter int          SAMPLE_W    = 14,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned BCLK_TMO    = 64,
  parameter int unsigned SYNC_TMO    = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_on,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                sdin,
  output logic                sdo_pull_low,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic                pwr_save
);
  logic [2:0] lvl;
  logic [1:0] prev;
  line_evt_t  evt;
  logic       frame_start, halt;
  logic [SAMPLE_W-1:0] tx_word;

  pcm_line_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin({sdin, fsync, bclk}), .level(lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl[1:0];
  end

  assign evt.bclk_rise = lvl[0] && !prev[0];
  assign evt.bclk_fall = !lvl[0] && prev[0];
  assign evt.fs_rise   = lvl[1] && !prev[1];

  pcm_activity_mon #(.BCLK_TMO(BCLK_TMO), .SYNC_TMO(SYNC_TMO)) u_mon (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
    .bclk_edge(evt.bclk_rise || evt.bclk_fall), .fs_rise(evt.fs_rise),
    .frame_start(frame_start), .halt(halt), .saving(pwr_save));

  assign tx_ready = frame_start;
  assign tx_word  = tx_valid ? tx_data : '0;

  pcm_tx_slot #(.W(SAMPLE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .halt(halt), .start(frame_start),
    .bclk_high(lvl[0]), .bclk_rise(evt.bclk_rise), .word(tx_word),
    .pull_low(sdo_pull_low));

  pcm_rx_slot #(.W(SAMPLE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .halt(halt), .flush(!pwr_on),
    .start(frame_start), .bclk_fall(evt.bclk_fall), .sdin(lvl[2]),
    .rdy(rx_ready), .data(rx_data), .valid(rx_valid));

  // R7: nothing is driven while saving power
  assert_quiet_in_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save |-> !sdo_pull_low);
  // R10: power down idles both directions
  assert_pdown_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (pwr_save && !rx_valid && !sdo_pull_low));
endmodule

// File: tb/pcm_frame_port_test.sv
module pcm_frame_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b1;
  logic bclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
  logic sdo_pull_low;
  logic [13:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [13:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b0;
  logic pwr_save;

  int checks = 0;
  int errors = 0;
  int ready_cnt = 0;

  always #2.5 clk = ~clk;

  pcm_frame_port uut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .bclk(bclk), .fsync(fsync),
    .sdin(sdin), .sdo_pull_low(sdo_pull_low), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .pwr_save(pwr_save));

  always @(negedge clk) if (tx_ready) ready_cnt <= ready_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Runs two lead bit periods and then a 16-period frame.
  // If cut < 16, the bit clock freezes high in period cut and the task returns.
  task automatic run_frame(input logic [13:0] rxw, input logic [13:0] txw,
                           input bit txv, input bit late, input int cut,
                           output logic [13:0] seen);
    seen = '0;
    tx_data = txw; tx_valid = txv;
    for (int p = 0; p < 2; p++) begin
      bclk = 1'b1; tick(8);
      bclk = 1'b0;
      if (late && p == 1) begin
        tick(4); fsync = 1'b1; tick(6);
        check(sdo_pull_low == 1'b0, "R4", "no launch before clock rise", sdo_pull_low, 0);
      end else tick(8);
    end
    for (int k = 0; k < 16; k++) begin
      bclk = 1'b1;
      sdin = (k < 14) ? rxw[13-k] : 1'b0;
      if (k == 0) fsync = 1'b1;
      if (k == 1) fsync = 1'b0;
      if (k == cut) begin
        tick(100);
        return;
      end
      tick(8);
      if (k < 14) seen[13-k] = ~sdo_pull_low;
      else check(sdo_pull_low == 1'b0, "R5", "released after slot", sdo_pull_low, 0);
      bclk = 1'b0; tick(8);
    end
    tx_valid = 1'b0;
  endtask

  task automatic take_rx();
    rx_ready = 1'b1; tick(1); rx_ready = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    check(pwr_save == 1'b1, "R9", "reset saving", pwr_save, 1);
    check(sdo_pull_low == 1'b0, "R9", "reset released", sdo_pull_low, 0);
    check(rx_valid == 1'b0, "R9", "reset no word", rx_valid, 0);
  endtask

  task automatic t_basic();
    logic [13:0] s;
    int r0 = ready_cnt;
    run_frame(14'h3FFE, 14'h1234, 1'b1, 1'b0, 99, s);
    check(s == 14'h1234, "R3", "tx bits sync-aligned", s, 14'h1234);
    check(ready_cnt == r0 + 1, "R3", "one ready pulse", ready_cnt, r0 + 1);
    check(rx_valid == 1'b1, "R2", "rx valid", rx_valid, 1);
    check(rx_data == 14'h3FFE, "R1", "rx word", rx_data, 14'h3FFE);
    check(pwr_save == 1'b0, "R9", "awake after frame", pwr_save, 0);
    take_rx();
    check(rx_valid == 1'b0, "R2", "valid drops after ready", rx_valid, 0);
  endtask

  task automatic t_late();
    logic [13:0] s;
    run_frame(14'h2000, 14'h0A5C, 1'b1, 1'b1, 99, s);
    check(s == 14'h0A5C, "R4", "tx bits late launch", s, 14'h0A5C);
    check(rx_data == 14'h2000, "R1", "rx most negative", rx_data, 14'h2000);
    take_rx();
  endtask

  task automatic t_no_tx();
    logic [13:0] s;
    run_frame(14'h1555, 14'h3FFF, 1'b0, 1'b0, 99, s);
    check(s == 14'h0000, "R6", "silence pulls low every bit", s, 0);
    check(rx_data == 14'h1555, "R1", "rx alternating", rx_data, 14'h1555);
    take_rx();
  endtask

  task automatic t_overwrite();
    logic [13:0] s;
    run_frame(14'h0111, 14'h0, 1'b1, 1'b0, 99, s);
    tick(20);
    check(rx_valid == 1'b1 && rx_data == 14'h0111, "R2", "held unread", rx_data, 14'h0111);
    run_frame(14'h2222, 14'h0, 1'b1, 1'b0, 99, s);
    check(rx_data == 14'h2222, "R2", "overwritten", rx_data, 14'h2222);
    take_rx();
    check(rx_valid == 1'b0, "R2", "taken", rx_valid, 0);
  endtask

  task automatic t_bclk_stall();
    logic [13:0] s;
    run_frame(14'h3FFF, 14'h0000, 1'b1, 1'b0, 3, s);
    check(pwr_save == 1'b1, "R7", "saving on clock stall", pwr_save, 1);
    check(sdo_pull_low == 1'b0, "R7", "released on stall", sdo_pull_low, 0);
    check(rx_valid == 1'b0, "R7", "partial word dropped", rx_valid, 0);
    bclk = 1'b0; tick(8);
    run_frame(14'h0ABC, 14'h3210, 1'b1, 1'b0, 99, s);
    check(s == 14'h3210 && pwr_save == 1'b0, "R9", "recovered tx", s, 14'h3210);
    check(rx_data == 14'h0ABC, "R9", "recovered rx", rx_data, 14'h0ABC);
    take_rx();
  endtask

  task automatic t_sync_stall();
    logic [13:0] s;
    for (int p = 0; p < 72; p++) begin
      bclk = 1'b1; tick(8); bclk = 1'b0; tick(8);
    end
    check(pwr_save == 1'b1, "R8", "saving on sync stall", pwr_save, 1);
    run_frame(14'h1F0F, 14'h2C3A, 1'b1, 1'b0, 99, s);
    check(s == 14'h2C3A, "R9", "wake on sync", s, 14'h2C3A);
    take_rx();
  endtask

  task automatic t_powerdown();
    logic [13:0] s;
    int r0;
    run_frame(14'h0F0F, 14'h0, 1'b1, 1'b0, 99, s);
    pwr_on = 1'b0; tick(2);
    check(pwr_save == 1'b1 && rx_valid == 1'b0, "R10", "idle on power down", rx_valid, 0);
    r0 = ready_cnt;
    run_frame(14'h1111, 14'h0, 1'b1, 1'b0, 99, s);
    check(s == 14'h3FFF, "R10", "no drive while down", s, 14'h3FFF);
    check(ready_cnt == r0 && rx_valid == 1'b0, "R10", "no frame while down", ready_cnt, r0);
    pwr_on = 1'b1; tick(2);
    run_frame(14'h0777, 14'h1999, 1'b1, 1'b0, 99, s);
    check(s == 14'h1999 && rx_data == 14'h0777, "R10", "works after power up", s, 14'h1999);
    take_rx();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(4); rst_n = 1'b1; tick(4);
    t_reset();
    t_basic();
    t_late();
    t_no_tx();
    t_overwrite();
    t_bclk_stall();
    t_sync_stall();
    t_powerdown();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule